// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block produces the raster position for a display controller. It keeps a horizontal pixel counter and a vertical line counter, and from them derives an active-display flag and single-cycle end-of-line and end-of-frame strobes. The counters advance only in cycles where the pixel-clock enable is high. Horizontal timing is programmed in 8-pixel character units and vertical timing in lines. Both are stored as the count minus one.

A host writes three 32-bit words one byte at a time through a write-only port. Word 0 holds horizontal timing, word 1 holds vertical timing and word 2 is the general control word. Setting the enable bit takes a snapshot of the timing fields and starts the raster at pixel 0 of line 0. Timing writes made while the raster runs are taken up at the next frame start. Clearing the enable bit halts the raster on the next clock. The control word also carries a mode bit and a 3-bit pixel depth code, and both are exported as status.

Top module: `crt_timing_gen`

## Requirements
- R1: After reset, h_count and v_count are 0; running, active, eol, eof, ext_mode are 0; depth_code is 0; depth_unsup is 1.
- R2: Byte address = word*4 + byte. Horizontal word bits [8:0] hold the total in characters minus one (HT). While running, h_count steps 0 .. (HT+1)*8-1 and wraps to 0. eol is high exactly while h_count is (HT+1)*8-1.
- R3: Horizontal word bits [23:16] hold the displayed characters minus one (HD). Vertical word bits [26:16] hold the displayed lines minus one (VD). active is high exactly when running, h_count < (HD+1)*8 and v_count <= VD.
- R4: Vertical word bits [10:0] hold the total lines minus one (VT). v_count increments when h_count wraps, and wraps from VT to 0. eof is high exactly while eol is high and v_count equals VT.
- R5: The counters change only on clocks where pix_en is 1, apart from the reset and disable cases.
- R6: Control word bit 25 is the enable. Writing it from 0 to 1 snapshots the timing fields and starts from (0,0), with running=1. Writing it to 0 forces both counters to 0 and running, active, eol and eof to 0 on the next clock.
- R7: Timing words written while running do not alter the current frame. They take effect from the frame that starts after the end-of-frame wrap.
- R8: ext_mode follows control word bit 24 (1 = extended, 0 = VGA), whether running or not.
- R9: depth_code is control word bits [10:8]. depth_unsup is 1 for codes 0 and 7 and 0 for codes 1 to 6 (4, 8, 15, 16, 24 and 32 bpp).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel per high cycle |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Byte address (word index in bits [3:2]) |
| wr_data | input | 8 | Byte write data |
| h_count | output | 12 | Current pixel within the line |
| v_count | output | 11 | Current line within the frame |
| active | output | 1 | Position is inside the displayed area |
| eol | output | 1 | Last pixel of a line |
| eof | output | 1 | Last pixel of the last line |
| running | output | 1 | Raster enabled |
| ext_mode | output | 1 | Extended (1) or VGA (0) mode bit |
| depth_code | output | 3 | Pixel depth code |
| depth_unsup | output | 1 | Depth code is not a supported format |

## Verification
The hardest case to reach is a timing rewrite during a running frame. The old geometry has to hold until the frame wraps, and the new geometry has to appear exactly at the wrap. The stimulus starts a short frame and rewrites the horizontal total partway through. It then follows eol to confirm the old line length holds for the rest of that frame and the new length holds after eof. Irregular pix_en patterns from an LFSR cover stalls on the last pixel of a line and of a frame. A disable write, made while the counters are far from zero, checks the immediate stop.

// File: rtl/crt_pkg.sv
package crt_pkg;
  // word indices in the register port (word = byte address / 4)
  localparam int unsigned W_HTIM = 0;
  localparam int unsigned W_VTIM = 1;
  localparam int unsigned W_CTRL = 2;
  localparam int unsigned NWORDS = 3;

  // control word bit positions
  localparam int unsigned CTRL_EXT_BIT   = 24;
  localparam int unsigned CTRL_EN_BIT    = 25;
  localparam int unsigned CTRL_DEPTH_LSB = 8;

  // second half of each timing word starts here
  localparam int unsigned UPPER_LSB = 16;

  typedef enum logic [2:0] {
    DEPTH_NONE = 3'd0,
    DEPTH_4P   = 3'd1,
    DEPTH_8P   = 3'd2,
    DEPTH_15   = 3'd3,
    DEPTH_16   = 3'd4,
    DEPTH_24   = 3'd5,
    DEPTH_32   = 3'd6,
    DEPTH_RSVD = 3'd7
  } depth_e;

  // pixels spanned by a count-minus-one character field
  function automatic int unsigned char_span_px(input int unsigned chars_m1,
                                               input int unsigned shift);
    return (chars_m1 + 1) << shift;
  endfunction

  function automatic logic depth_known(input logic [2:0] code);
    return (code != DEPTH_NONE) && (code != DEPTH_RSVD);
  endfunction
endpackage

// File: rtl/crt_regfile.sv
module crt_regfile #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NUM_W  = crt_pkg::NWORDS,
  parameter int unsigned CTRL_W = crt_pkg::W_CTRL,
  parameter int unsigned EN_BIT = crt_pkg::CTRL_EN_BIT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [7:0]                   wr_data,
  output logic [NUM_W-1:0][31:0]       words,
  output logic                         start_evt,
  output logic                         stop_evt
);
  localparam int unsigned EN_BYTE = EN_BIT / 8;
  localparam int unsigned EN_POS  = EN_BIT % 8;

  logic ctrl_en_byte_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < int'(NUM_W); w++) begin
        for (int b = 0; b < 4; b++) begin
          if (wr_addr == ADDR_W'(w * 4 + b)) words[w][b*8 +: 8] <= wr_data;
        end
      end
    end
  end

  assign ctrl_en_byte_wr = wr_en && (wr_addr == ADDR_W'(CTRL_W * 4 + EN_BYTE));
  assign start_evt = ctrl_en_byte_wr && wr_data[EN_POS] && !words[CTRL_W][EN_BIT];
  assign stop_evt  = ctrl_en_byte_wr && !wr_data[EN_POS];
endmodule

// File: rtl/crt_shadow.sv
module crt_shadow #(
  parameter int unsigned H_TOT_W  = 9,
  parameter int unsigned H_DISP_W = 8,
  parameter int unsigned V_W      = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [H_TOT_W-1:0]  in_htot,
  input  logic [H_DISP_W-1:0] in_hdisp,
  input  logic [V_W-1:0]      in_vtot,
  input  logic [V_W-1:0]      in_vdisp,
  output logic [H_TOT_W-1:0]  sh_htot,
  output logic [H_DISP_W-1:0] sh_hdisp,
  output logic [V_W-1:0]      sh_vtot,
  output logic [V_W-1:0]      sh_vdisp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_htot  <= '0;
      sh_hdisp <= '0;
      sh_vtot  <= '0;
      sh_vdisp <= '0;
    end else if (load) begin
      sh_htot  <= in_htot;
      sh_hdisp <= in_hdisp;
      sh_vtot  <= in_vtot;
      sh_vdisp <= in_vdisp;
    end
  end
endmodule

// File: rtl/crt_counters.sv
module crt_counters #(
  parameter int unsigned HPX_W = 12,
  parameter int unsigned V_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [HPX_W-1:0] h_last,
  input  logic [V_W-1:0]   v_last,
  output logic [HPX_W-1:0] h_q,
  output logic [V_W-1:0]   v_q,
  output logic             line_end,
  output logic             frame_end
);
  assign line_end  = (h_q == h_last);
  assign frame_end = line_end && (v_q == v_last);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      h_q <= '0;
      v_q <= '0;
    end else if (step) begin
      if (line_end) begin
        h_q <= '0;
        v_q <= (v_q == v_last) ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen #(
  parameter int unsigned H_TOT_W    = 9,
  parameter int unsigned H_DISP_W   = 8,
  parameter int unsigned V_W        = 11,
  parameter int unsigned CHAR_SHIFT = 3,
  parameter int unsigned ADDR_W     = 4,
  localparam int unsigned HPX_W     = H_TOT_W + CHAR_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [HPX_W-1:0]  h_count,
  output logic [V_W-1:0]    v_count,
  output logic              active,
  output logic              eol,
  output logic              eof,
  output logic              running,
  output logic              ext_mode,
  output logic [2:0]        depth_code,
  output logic              depth_unsup
);
  import crt_pkg::*;

  logic [NWORDS-1:0][31:0] words;
  logic                    start_evt, stop_evt;
  logic [H_TOT_W-1:0]      sh_htot;
  logic [H_DISP_W-1:0]     sh_hdisp;
  logic [V_W-1:0]          sh_vtot, sh_vdisp;
  logic [HPX_W-1:0]        h_last;
  logic                    line_end, frame_end;
  logic                    frame_wrap, snap_load, cnt_clear;
  logic                    h_in_disp, v_in_disp;

  crt_regfile #(.ADDR_W(ADDR_W), .NUM_W(NWORDS), .CTRL_W(W_CTRL),
                .EN_BIT(CTRL_EN_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .words(words), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign running     = words[W_CTRL][CTRL_EN_BIT];
  assign ext_mode    = words[W_CTRL][CTRL_EXT_BIT];
  assign depth_code  = words[W_CTRL][CTRL_DEPTH_LSB +: 3];
  assign depth_unsup = !depth_known(depth_code);

  // snapshot on enable, refresh at each frame wrap
  assign cnt_clear  = !running || stop_evt;
  assign frame_wrap = !cnt_clear && pix_en && frame_end;
  assign snap_load  = start_evt || frame_wrap;

  crt_shadow #(.H_TOT_W(H_TOT_W), .H_DISP_W(H_DISP_W), .V_W(V_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(snap_load),
    .in_htot (words[W_HTIM][H_TOT_W-1:0]),
    .in_hdisp(words[W_HTIM][UPPER_LSB +: H_DISP_W]),
    .in_vtot (words[W_VTIM][V_W-1:0]),
    .in_vdisp(words[W_VTIM][UPPER_LSB +: V_W]),
    .sh_htot(sh_htot), .sh_hdisp(sh_hdisp), .sh_vtot(sh_vtot), .sh_vdisp(sh_vdisp)
  );

  assign h_last = HPX_W'(char_span_px(32'(sh_htot), CHAR_SHIFT) - 1);

  crt_counters #(.HPX_W(HPX_W), .V_W(V_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .step(pix_en),
    .h_last(h_last), .v_last(sh_vtot), .h_q(h_count), .v_q(v_count),
    .line_end(line_end), .frame_end(frame_end)
  );

  assign h_in_disp = 32'(h_count) < char_span_px(32'(sh_hdisp), CHAR_SHIFT);
  assign v_in_disp = v_count <= sh_vdisp;
  assign active    = running && h_in_disp && v_in_disp;
  assign eol       = running && line_end;
  assign eof       = running && frame_end;
endmodule

// File: rtl/crt_timing_gen_chk.sv
module crt_timing_gen_chk #(
  parameter int unsigned HPX_W = 12,
  parameter int unsigned V_W   = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic             wr_en,
  input logic             running,
  input logic [HPX_W-1:0] h_count,
  input logic [V_W-1:0]   v_count,
  input logic             active,
  input logic             eol,
  input logic             eof
);
  // R2: a stepped line end returns the pixel counter to zero
  a_r2_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pix_en && eol) |=> (h_count == '0));

  // R4: a stepped line end that is not a frame end advances the line
  a_r4_v_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pix_en && eol && !eof && !wr_en) |=> (v_count == V_W'($past(v_count) + 1'b1)));

  // R4: end of frame only on a line end
  a_r4_eof_in_eol: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> eol);

  // R5: without a pixel enable or a write, the position holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pix_en && !wr_en) |=> ($stable(h_count) && $stable(v_count)));

  // R6: while disabled everything is parked
  a_r6_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (h_count == '0 && v_count == '0 && !active && !eol && !eof));
endmodule

bind crt_timing_gen crt_timing_gen_chk #(.HPX_W(HPX_W), .V_W(V_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en), .running(running),
  .h_count(h_count), .v_count(v_count), .active(active), .eol(eol), .eof(eof)
);

// File: tb/crt_timing_gen_bench.sv
module crt_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] h_count;
  logic [10:0] v_count;
  logic        active, eol, eof, running, ext_mode, depth_unsup;
  logic [2:0]  depth_code;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit cmp_on = 0;
  bit done = 0;

  // behavioural reference state
  int m_reg [16];
  int m_h, m_v, s_ht, s_hd, s_vt, s_vd;

  always #5 clk = ~clk;

  crt_timing_gen u_crt_timing_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .h_count(h_count), .v_count(v_count), .active(active),
    .eol(eol), .eof(eof), .running(running), .ext_mode(ext_mode),
    .depth_code(depth_code), .depth_unsup(depth_unsup)
  );

  function automatic int r_en();   return (m_reg[11] >> 1) & 1; endfunction
  function automatic int r_ext();  return m_reg[11] & 1;        endfunction
  function automatic int r_dep();  return m_reg[9] & 7;         endfunction
  function automatic int line_px(); return (s_ht + 1) * 8;      endfunction

  task automatic snapshot();
    s_ht = m_reg[0] + (m_reg[1] & 1) * 256;
    s_hd = m_reg[2];
    s_vt = m_reg[4] + (m_reg[5] & 7) * 256;
    s_vd = m_reg[6] + (m_reg[7] & 7) * 256;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_h = 0; m_v = 0; s_ht = 0; s_hd = 0; s_vt = 0; s_vd = 0;
    end else begin
      bit en_wr, clr;
      en_wr = wr_en && wr_addr == 4'd11;
      clr = (r_en() == 0) || (en_wr && !wr_data[1]);
      if (en_wr && wr_data[1] && r_en() == 0) snapshot();
      if (clr) begin
        m_h = 0; m_v = 0;
      end else if (pix_en) begin
        if (m_h == line_px() - 1) begin
          m_h = 0;
          if (m_v == s_vt) begin
            m_v = 0;
            snapshot();
          end else m_v = m_v + 1;
        end else m_h = m_h + 1;
      end
      if (wr_en) m_reg[wr_addr] = wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int e_run, e_eol, e_eof, e_act, e_uns;
      e_run = r_en();
      e_eol = (e_run != 0 && m_h == line_px() - 1) ? 1 : 0;
      e_eof = (e_eol != 0 && m_v == s_vt) ? 1 : 0;
      e_act = (e_run != 0 && m_h < (s_hd + 1) * 8 && m_v <= s_vd) ? 1 : 0;
      e_uns = (r_dep() == 0 || r_dep() == 7) ? 1 : 0;
      chk(int'(h_count) == m_h, "R2 h_count", int'(h_count), m_h);
      chk(int'(v_count) == m_v, "R4 v_count", int'(v_count), m_v);
      chk(int'(eol) == e_eol, "R2 eol", int'(eol), e_eol);
      chk(int'(eof) == e_eof, "R4 eof", int'(eof), e_eof);
      chk(int'(active) == e_act, "R3 active", int'(active), e_act);
      chk(int'(running) == e_run, "R6 running", int'(running), e_run);
      chk(int'(ext_mode) == r_ext(), "R8 ext_mode", int'(ext_mode), r_ext());
      chk(int'(depth_code) == r_dep(), "R9 depth_code", int'(depth_code), r_dep());
      chk(int'(depth_unsup) == e_uns, "R9 depth_unsup", int'(depth_unsup), e_uns);
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input bit irregular);
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pix_en = irregular ? (lfsr[1:0] != 2'b00) : 1'b1;
    end
  endtask

  task automatic wait_eol();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (eol) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(h_count == 0 && v_count == 0, "R1 counters", int'(h_count), 0);
    chk(!running && !active && !eol && !eof && !ext_mode, "R1 flags", int'(running), 0);
    chk(depth_code == 0 && depth_unsup, "R1 depth_unsup", int'(depth_unsup), 1);
    cmp_on = 1;

    // 32 px lines (16 displayed), 5 lines (3 displayed)
    wr(0, 3); wr(1, 0); wr(2, 1);
    wr(4, 4); wr(5, 0); wr(6, 2); wr(7, 0);
    wr(9, 4);
    chk(running == 0 && h_count == 0, "R6 idle before enable", int'(running), 0);
    wr(11, 8'h03);                       // enable + extended
    chk(running && h_count == 0 && v_count == 0, "R6 start at origin", int'(h_count), 0);
    chk(ext_mode == 1, "R8 extended", int'(ext_mode), 1);
    run(400, 1'b1);

    // R5: stall keeps position
    begin
      int h0, v0;
      @(negedge clk); pix_en = 1'b0;
      @(negedge clk); h0 = int'(h_count); v0 = int'(v_count);
      repeat (10) @(negedge clk);
      chk(int'(h_count) == h0 && int'(v_count) == v0, "R5 stall", int'(h_count), h0);
    end

    // R7: change line length mid-frame
    run(1, 1'b0);
    while (v_count != 1) run(1, 1'b0);
    wr(0, 5);                            // new total 48 px
    pix_en = 1'b1;
    wait_eol();
    chk(h_count == 31, "R7 old line length held", int'(h_count), 31);
    while (!eof) run(1, 1'b0);
    run(1, 1'b0);
    wait_eol();
    chk(h_count == 47, "R7 new line length after wrap", int'(h_count), 47);

    // R9: every depth code
    for (int c = 0; c < 8; c++) begin
      wr(9, c);
      chk(int'(depth_code) == c, "R9 code", int'(depth_code), c);
      chk(depth_unsup == (c == 0 || c == 7), "R9 unsupported", int'(depth_unsup),
          (c == 0 || c == 7) ? 1 : 0);
    end

    // R6: stop away from origin
    run(25, 1'b0);
    wr(11, 8'h01);
    chk(!running && h_count == 0 && v_count == 0 && !active, "R6 stop", int'(h_count), 0);
    chk(ext_mode == 1, "R8 kept while stopped", int'(ext_mode), 1);
    run(20, 1'b1);
    wr(11, 8'h00);
    chk(ext_mode == 0, "R8 VGA", int'(ext_mode), 0);

    // restart with single-line frame and wide display
    wr(0, 0); wr(2, 9); wr(4, 0); wr(6, 0);
    wr(11, 8'h02);
    run(100, 1'b1);
    run(60, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule